// File: doc/BRIEF.md
# Watchdog Timer with Acknowledged Clear

This block is a memory-mapped watchdog. Software chooses a timeout that is a power of two between 1 and 128 seconds, then starts the counter. After that it must keep refreshing the counter by writing a clear command. If it misses a refresh, the counter expires. Expiry raises an interrupt. Depending on an action-select register, it also raises a reset request. A prescaler turns a configurable number of clock ticks into one second, so a simulation can use short timeouts.

The timeout register holds a coded value: code 3 means 1 second, and each higher code doubles the time. Enabling and clearing are not instant. A status flag in the control register tells software when a restart has taken hold. It also tells software when the counter has fully stopped after a disable. Software polls this flag before it continues.

Top module: `wdog_timer`

## Requirements
- R1: After reset the enable bit is 0, the timeout code reads 9 (64 s), the action select reads 0, the status flag is 0, and both expiry outputs are low.
- R2: Reads return data on the clock edge after the request. The timeout code is in bits [3:0] at word 0x3004. The action select is in bits [1:0] at word 0x3008. Any other address, or a cycle with no read request, returns 0.
- R3: The control word is at 0x300C. Bit 0 is enable and reads back as written. Bit 1 is clear and always reads back as 0. Bit 8 is the read-only status flag.
- R4: From the edge that restarts the counter, expiry is registered after TICKS_PER_SEC × 2^(code−3) clock edges, for codes 3 to 10.
- R5: A code below 3 behaves as 3, and a code above 10 behaves as 10. The register still reads back the raw value written.
- R6: The timeout code is only sampled at a restart. Writing a new code while the counter runs does not change the timeout in progress.
- R7: A restart is a control write with enable=1 and clear=1. While running, it reloads the full timeout. A write of clear with enable=0 does not start the counter.
- R8: At a restart the status flag drops to 0 on that same edge. It reads 1 from STATUS_LAG edges later. After a disable, it falls STATUS_LAG edges after the write.
- R9: At expiry the interrupt output asserts. If the action select equals 2, only the interrupt asserts. Any other select value asserts the reset request as well. The select value is latched at the expiry edge.
- R10: Both expiry outputs stay high until the next restart or the next control write with enable=0, whichever comes first.
- R11: A control write with enable=1 while the counter is stopped is a restart even without clear. The same write while the counter runs has no effect on the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read data, valid the cycle after the request |
| irq_o | output | 1 | Expiry interrupt, held until restart or disable |
| wdt_rst_o | output | 1 | Expiry reset request, held until restart or disable |

## Verification
The assertions check four rules on every cycle. A reset request never appears without the interrupt. Both outputs stay high until a restart or a disable clears them. A restart drops the status flag on the next cycle and clears any expiry. An interrupt can only rise while the counter is enabled. The exact expiry cycle for each code, the saturation of out-of-range codes, and the fact that a mid-run code write is ignored can only be shown by the bench scenarios. The same holds for the lag of the status flag and for ignored clears and repeated enables. The bench compares those against its cycle-level model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Word offsets decoded by software drivers.
  localparam int OFF_PERIOD = 'h3004;
  localparam int OFF_ACTION = 'h3008;
  localparam int OFF_CTRL   = 'h300C;

  localparam int CODE_W     = 4;
  localparam int SEL_W      = 2;
  localparam int CODE_MIN   = 3;   // 1 second
  localparam int CODE_MAX   = 10;  // 128 seconds
  localparam int CODE_RESET = 9;   // 64 seconds
  localparam int SEC_W      = 8;   // holds up to 128
  localparam int STAT_BIT   = 8;

  localparam logic [SEL_W-1:0] SEL_IRQ_ONLY = 2'd2;

  // Clamp an arbitrary code into the legal window.
  function automatic logic [CODE_W-1:0] sat_code(input logic [CODE_W-1:0] c);
    if (c < CODE_W'(CODE_MIN)) return CODE_W'(CODE_MIN);
    if (c > CODE_W'(CODE_MAX)) return CODE_W'(CODE_MAX);
    return c;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              status,
  output logic [DATA_W-1:0] rd_data,
  output logic              en_q,
  output logic [CODE_W-1:0] code_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              restart,
  output logic              halt
);

  logic wr_ctrl, wr_period, wr_action;
  logic unused_wdata;

  assign wr_ctrl   = wr_en && (wr_addr == ADDR_W'(OFF_CTRL));
  assign wr_period = wr_en && (wr_addr == ADDR_W'(OFF_PERIOD));
  assign wr_action = wr_en && (wr_addr == ADDR_W'(OFF_ACTION));

  // Restart: enable with clear, or enable while stopped.
  assign restart = wr_ctrl && wr_data[0] && (wr_data[1] || !en_q);
  assign halt    = wr_ctrl && !wr_data[0];

  assign unused_wdata = ^wr_data[DATA_W-1:CODE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      code_q <= CODE_W'(CODE_RESET);
      sel_q  <= '0;
    end else begin
      if (wr_ctrl)   en_q   <= wr_data[0];
      if (wr_period) code_q <= wr_data[CODE_W-1:0];
      if (wr_action) sel_q  <= wr_data[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (rd_en) begin
        if (rd_addr == ADDR_W'(OFF_PERIOD)) begin
          rd_data[CODE_W-1:0] <= code_q;
        end else if (rd_addr == ADDR_W'(OFF_ACTION)) begin
          rd_data[SEL_W-1:0] <= sel_q;
        end else if (rd_addr == ADDR_W'(OFF_CTRL)) begin
          rd_data[0]        <= en_q;
          rd_data[STAT_BIT] <= status;
        end
      end
    end
  end

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int TICKS_PER_SEC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic sec_tick
);

  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0] cnt;

  assign sec_tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int STATUS_LAG = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              halt,
  input  logic              en_q,
  input  logic [CODE_W-1:0] code_q,
  input  logic [SEL_W-1:0]  sel_q,
  input  logic              sec_tick,
  output logic              run,
  output logic              status,
  output logic              irq_o,
  output logic              wdt_rst_o
);

  logic                 active;
  logic [SEC_W-1:0]     secs;
  logic [SEC_W-1:0]     lim_q;
  logic [SEC_W-1:0]     lim_next;
  logic [STATUS_LAG-1:0] pipe;

  assign lim_next = SEC_W'(1) << (sat_code(code_q) - CODE_W'(CODE_MIN));
  assign run      = active && !irq_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      secs      <= '0;
      lim_q     <= '0;
      irq_o     <= 1'b0;
      wdt_rst_o <= 1'b0;
    end else if (restart) begin
      active    <= 1'b1;
      secs      <= '0;
      lim_q     <= lim_next;
      irq_o     <= 1'b0;
      wdt_rst_o <= 1'b0;
    end else if (halt) begin
      active    <= 1'b0;
      irq_o     <= 1'b0;
      wdt_rst_o <= 1'b0;
    end else if (sec_tick) begin
      if (secs == lim_q - 1'b1) begin
        irq_o     <= 1'b1;
        wdt_rst_o <= (sel_q != SEL_IRQ_ONLY);
      end else begin
        secs <= secs + 1'b1;
      end
    end
  end

  // Status: delayed view of enable; a restart wipes the history.
  generate
    if (STATUS_LAG > 1) begin : g_pipe
      always_ff @(posedge clk) begin
        if (rst || restart) pipe <= '0;
        else                pipe <= {pipe[STATUS_LAG-2:0], en_q};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst || restart) pipe <= '0;
        else                pipe <= en_q;
      end
    end
  endgenerate

  assign status = pipe[STATUS_LAG-1];

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 32,
  parameter int TICKS_PER_SEC = 1000,
  parameter int STATUS_LAG    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o,
  output logic              wdt_rst_o
);

  logic              en_q, restart, halt, status, run, sec_tick;
  logic [CODE_W-1:0] code_q;
  logic [SEL_W-1:0]  sel_q;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .status(status), .rd_data(rd_data),
    .en_q(en_q), .code_q(code_q), .sel_q(sel_q),
    .restart(restart), .halt(halt)
  );

  wdog_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst(rst), .clr(restart || halt), .run(run), .sec_tick(sec_tick)
  );

  wdog_core #(.STATUS_LAG(STATUS_LAG)) u_core (
    .clk(clk), .rst(rst), .restart(restart), .halt(halt),
    .en_q(en_q), .code_q(code_q), .sel_q(sel_q), .sec_tick(sec_tick),
    .run(run), .status(status), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic clk,
  input logic rst,
  input logic irq_o,
  input logic wdt_rst_o,
  input logic restart,
  input logic halt,
  input logic en_q,
  input logic status
);

  p_rst_needs_irq_r9: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_o |-> irq_o);

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !restart && !halt) |=> irq_o);

  p_rst_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (wdt_rst_o && !restart && !halt) |=> wdt_rst_o);

  p_halt_clears_r10: assert property (@(posedge clk) disable iff (rst)
    halt |=> (!irq_o && !wdt_rst_o));

  p_restart_status_low_r8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!status && !irq_o));

  p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> en_q);

endmodule

bind wdog_timer wdog_timer_chk u_chk (.*);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;

  localparam int AW  = 16;
  localparam int DW  = 32;
  localparam int TPS = 4;
  localparam int LAG = 3;
  localparam logic [15:0] A_PER = 16'h3004, A_ACT = 16'h3008, A_CTL = 16'h300C;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic irq_o, wdt_rst_o;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  logic [DW-1:0] got;

  always #4 clk = ~clk;

  wdog_timer #(.ADDR_W(AW), .DATA_W(DW), .TICKS_PER_SEC(TPS), .STATUS_LAG(LAG)) i_wdog_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model state.
  int m_en, m_code, m_sel, m_run, m_left, m_irq, m_rst;
  logic [DW-1:0] m_rd;
  bit st_q[$];

  function automatic int eff_code(input int c);
    if (c < 3) return 3;
    if (c > 10) return 10;
    return c;
  endfunction

  always @(posedge clk) begin
    bit rs, hl, st;
    if (rst) begin
      m_en = 0; m_code = 9; m_sel = 0; m_run = 0; m_left = 0;
      m_irq = 0; m_rst = 0; m_rd = '0;
      st_q.delete();
      for (int i = 0; i < LAG; i++) st_q.push_back(1'b0);
    end else begin
      st = st_q[$];
      m_rd = '0;
      if (rd_en) begin
        if (rd_addr == A_PER) m_rd = DW'(m_code);
        else if (rd_addr == A_ACT) m_rd = DW'(m_sel);
        else if (rd_addr == A_CTL) m_rd = DW'(m_en) | (DW'(st) << 8);
      end
      rs = wr_en && wr_addr == A_CTL && wr_data[0] && (wr_data[1] || m_en == 0);
      hl = wr_en && wr_addr == A_CTL && !wr_data[0];
      if (rs) begin
        foreach (st_q[i]) st_q[i] = 1'b0;
      end else begin
        st_q.push_front(m_en != 0);
        void'(st_q.pop_back());
      end
      if (rs) begin
        m_run = 1; m_irq = 0; m_rst = 0;
        m_left = TPS * (1 << (eff_code(m_code) - 3));
      end else if (hl) begin
        m_run = 0; m_irq = 0; m_rst = 0;
      end else if (m_run != 0 && m_irq == 0) begin
        m_left--;
        if (m_left == 0) begin
          m_irq = 1; m_rst = (m_sel != 2) ? 1 : 0;
        end
      end
      if (wr_en && wr_addr == A_CTL) m_en = wr_data[0];
      if (wr_en && wr_addr == A_PER) m_code = int'(wr_data[3:0]);
      if (wr_en && wr_addr == A_ACT) m_sel = int'(wr_data[1:0]);
    end
    #2;
    if (!rst) begin
      chk({cur_req, " rd_data R2"}, rd_data, m_rd);
      chk({cur_req, " irq"}, DW'(irq_o), DW'(m_irq));
      chk({cur_req, " rst req"}, DW'(wdt_rst_o), DW'(m_rst));
    end
  end

  task automatic wr(input logic [15:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    while (cycles < 20000) begin @(posedge clk); cycles++; end
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst = 1'b0; idle(1);
    // R1 reset values
    cur_req = "R1";
    rd(A_PER, got); chk("R1 code", got, 32'd9);
    rd(A_ACT, got); chk("R1 select", got, 32'd0);
    rd(A_CTL, got); chk("R1 ctrl", got, 32'd0);
    chk("R1 irq", DW'(irq_o), 0);
    rd(16'h3000, got); chk("R2 unmapped", got, 32'd0);
    // R2 readback of raw fields
    cur_req = "R2";
    wr(A_PER, 32'hFFFF_FFF5); rd(A_PER, got); chk("R2 code", got, 32'd5);
    wr(A_ACT, 32'd3); rd(A_ACT, got); chk("R2 select", got, 32'd3);
    // R11 enable from stopped, code 3 -> TPS cycles
    cur_req = "R11";
    wr(A_ACT, 32'd0); wr(A_PER, 32'd3);
    wr(A_CTL, 32'd1);
    idle(TPS - 1); chk("R4 before expiry", DW'(irq_o), 0);
    idle(1); chk("R4 at expiry", DW'(irq_o), 1);
    chk("R9 both", DW'(wdt_rst_o), 1);
    cur_req = "R10";
    idle(6); chk("R10 sticky", DW'(irq_o), 1);
    // R3 control readback, clear bit reads 0
    cur_req = "R3";
    wr(A_CTL, 32'd3); rd(A_CTL, got); chk("R3 ctrl no clear bit", got & 32'h3, 32'd1);
    chk("R8 status low soon after restart", got >> 8, 32'd0);
    idle(LAG); rd(A_CTL, got); chk("R8 status high", got >> 8, 32'd1);
    idle(8);
    // R10 disable clears outputs, R8 status falls
    cur_req = "R8";
    wr(A_CTL, 32'd0); chk("R10 disable clears", DW'(irq_o), 0);
    idle(LAG + 1); rd(A_CTL, got); chk("R8 status low after disable", got, 32'd0);
    // R7 clear with enable 0 does not start
    cur_req = "R7";
    wr(A_CTL, 32'd2); idle(3 * TPS); chk("R7 no start", DW'(irq_o), 0);
    // R9 irq only, code 5
    cur_req = "R9";
    wr(A_ACT, 32'd2); wr(A_PER, 32'd5); wr(A_CTL, 32'd3);
    idle(4 * TPS - 1); chk("R9 before", DW'(irq_o), 0);
    idle(1); chk("R9 irq", DW'(irq_o), 1); chk("R9 no reset", DW'(wdt_rst_o), 0);
    // R7 refresh defers expiry
    cur_req = "R7";
    wr(A_ACT, 32'd1); wr(A_CTL, 32'd3);
    idle(10); wr(A_CTL, 32'd3);
    idle(4 * TPS - 1); chk("R7 refreshed", DW'(irq_o), 0);
    idle(1); chk("R7 expiry after refresh", DW'(irq_o), 1);
    // R6 code write during run ignored; R11 enable rewrite ignored
    cur_req = "R6";
    wr(A_PER, 32'd4); wr(A_CTL, 32'd3);
    wr(A_PER, 32'd10); idle(2);
    wr(A_CTL, 32'd1);
    idle(2 * TPS - 5); chk("R6 old timeout holds", DW'(irq_o), 1);
    // R5 saturation low and high
    cur_req = "R5";
    wr(A_CTL, 32'd0); wr(A_PER, 32'd0); wr(A_CTL, 32'd3);
    idle(TPS - 1); chk("R5 low before", DW'(irq_o), 0);
    idle(1); chk("R5 low sat", DW'(irq_o), 1);
    wr(A_CTL, 32'd0); wr(A_PER, 32'd15); wr(A_CTL, 32'd3);
    idle(128 * TPS - 1); chk("R5 high before", DW'(irq_o), 0);
    idle(1); chk("R5 high sat", DW'(irq_o), 1);
    rd(A_PER, got); chk("R5 raw readback", got, 32'd15);
    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule